// File: doc/BRIEF.md
# Sixteen-Bit Cascaded ALU with Carry Look-Ahead

This block is a combinational 16-bit arithmetic logic unit assembled from four 4-bit slices that share one 3-bit operation select. It offers three arithmetic operations (addition and the two subtraction orders), three bitwise operations (exclusive-or, inclusive-or, and), and two constant results (all zeros and all ones). A subtraction works by inverting one operand and adding the carry-in, so the caller drives the carry-in to 1 for a true difference.

The three low slices each report a group propagate and a group generate term. A look-ahead unit turns these terms and the external carry-in into the carries for slices 1, 2 and 3 at once, so no carry ripples from one slice to the next. The most significant slice has no group terms of its own. It resolves the final carry-out and the two's-complement overflow flag instead.

Top module: `alu16Cascade`

## Requirements
- R1: With select 0 (clear), F is 0x0000, and carry-out and overflow are both 0, whatever A, B and carry-in are.
- R2: With select 7 (preset), F is 0xFFFF, and carry-out and overflow are both 0, whatever A, B and carry-in are.
- R3: With select 3 (add), the 17-bit value {carry-out, F} equals A + B + carry-in.
- R4: With select 2 (A minus B), {carry-out, F} equals A + ~B + carry-in. With carry-in 1 this gives F = A - B mod 2^16, and carry-out is 1 exactly when A >= B unsigned.
- R5: With select 1 (B minus A), {carry-out, F} equals B + ~A + carry-in. With carry-in 1 this gives F = B - A mod 2^16.
- R6: With select 4 the result is F = A xor B, with select 5 it is F = A or B, and with select 6 it is F = A and B. In all three, carry-out and overflow are 0.
- R7: In the arithmetic selects (1, 2, 3), overflow is 1 exactly when the two effective operands (after any inversion) share a sign bit (bit 15) and bit 15 of F differs from it. This equals the carry into bit 15 xor the carry out of bit 15.
- R8: A carry made in any slice reaches every higher slice within the same evaluation. Examples: 0x0FFF + 1 gives 0x1000, and 0xFFFF + 0 with carry-in 1 gives F = 0x0000 with carry-out 1.
- R9: In the select codes 0 and 4 through 7, the carry-in has no effect on F, carry-out or overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opSel | input | 3 | Operation select (0 clear, 1 B-A, 2 A-B, 3 add, 4 xor, 5 or, 6 and, 7 preset) |
| carryIn | input | 1 | Carry into the least significant slice |
| resF | output | 16 | Result word |
| carryOut | output | 1 | Carry out of bit 15 (arithmetic selects only) |
| overflow | output | 1 | Two's-complement overflow (arithmetic selects only) |

## Verification
The assertions are immediate checks on purely combinational paths. They assume that every input holds a known 0/1 value while it is evaluated, and that all eight select codes are legal. The bench meets this by driving every input from tasks, starting from defined values, and by changing inputs only one time unit after a clock edge. Outputs are read several time units later, once the logic has settled. Random operands are drawn as full 16-bit words, and every one of the eight select codes is covered.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int SLICE_W    = 4;
  localparam int NUM_SLICES = 4;
  localparam int DATA_W     = SLICE_W * NUM_SLICES;
  localparam int SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    OP_CLEAR  = 3'd0,
    OP_BSUBA  = 3'd1,
    OP_ASUBB  = 3'd2,
    OP_ADD    = 3'd3,
    OP_XOR    = 3'd4,
    OP_OR     = 3'd5,
    OP_AND    = 3'd6,
    OP_PRESET = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LOG_XOR = 2'd0,
    LOG_OR  = 2'd1,
    LOG_AND = 2'd2
  } logicOp_e;

  // Strobes from the decoder to every slice
  typedef struct packed {
    logic     arithEn;
    logic     invA;
    logic     invB;
    logic     forceLow;
    logic     forceHigh;
    logicOp_e logicOp;
  } aluStrobes_t;

  typedef struct packed {
    logic [SLICE_W-1:0] sum;
    logic               carryOut;
    logic               grpProp;
    logic               grpGen;
  } sliceCore_t;

  // Sum and group carry terms of one slice of effective operands
  function automatic sliceCore_t sliceCore(input logic [SLICE_W-1:0] aEff,
                                           input logic [SLICE_W-1:0] bEff,
                                           input logic               cin);
    sliceCore_t r;
    logic       c;
    c         = cin;
    r.grpProp = 1'b1;
    r.grpGen  = 1'b0;
    for (int i = 0; i < SLICE_W; i++) begin
      r.sum[i]  = aEff[i] ^ bEff[i] ^ c;
      c         = (aEff[i] & bEff[i]) | ((aEff[i] | bEff[i]) & c);
      r.grpGen  = (aEff[i] & bEff[i]) | ((aEff[i] | bEff[i]) & r.grpGen);
      r.grpProp = r.grpProp & (aEff[i] | bEff[i]);
    end
    r.carryOut = c;
    return r;
  endfunction

  // Final per-slice result selection
  function automatic logic [SLICE_W-1:0] sliceResult(input aluStrobes_t        s,
                                                     input logic [SLICE_W-1:0] a,
                                                     input logic [SLICE_W-1:0] b,
                                                     input logic [SLICE_W-1:0] sum);
    logic [SLICE_W-1:0] r;
    if (s.forceLow)       r = '0;
    else if (s.forceHigh) r = '1;
    else if (s.arithEn)   r = sum;
    else begin
      case (s.logicOp)
        LOG_XOR: r = a ^ b;
        LOG_OR:  r = a | b;
        LOG_AND: r = a & b;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/alu16Ctrl.sv
module alu16Ctrl
  import alu16_pkg::*;
(
  input  logic [SEL_W-1:0] opSel,
  output aluStrobes_t      strobes
);

  always_comb begin
    strobes = '{arithEn: 1'b0, invA: 1'b0, invB: 1'b0,
                forceLow: 1'b0, forceHigh: 1'b0, logicOp: LOG_XOR};
    case (aluOp_e'(opSel))
      OP_CLEAR:  strobes.forceLow  = 1'b1;
      OP_BSUBA:  begin strobes.arithEn = 1'b1; strobes.invA = 1'b1; end
      OP_ASUBB:  begin strobes.arithEn = 1'b1; strobes.invB = 1'b1; end
      OP_ADD:    strobes.arithEn   = 1'b1;
      OP_XOR:    strobes.logicOp   = LOG_XOR;
      OP_OR:     strobes.logicOp   = LOG_OR;
      OP_AND:    strobes.logicOp   = LOG_AND;
      OP_PRESET: strobes.forceHigh = 1'b1;
      default:   strobes.forceLow  = 1'b1;
    endcase
  end

  always_comb begin
    AST_ONE_RESULT_SOURCE: assert ($onehot0({strobes.arithEn, strobes.forceLow, strobes.forceHigh}))
      else $error("more than one result source selected"); // R6
    AST_SINGLE_INVERT: assert (!(strobes.invA && strobes.invB))
      else $error("both operands inverted"); // R4
    AST_INVERT_ONLY_ARITH: assert (strobes.arithEn || !(strobes.invA || strobes.invB))
      else $error("inversion outside arithmetic"); // R5
  end

endmodule

// File: rtl/alu16Lookahead.sv
module alu16Lookahead #(
  parameter int NUM_GRP = 3
) (
  input  logic [NUM_GRP-1:0] grpProp,
  input  logic [NUM_GRP-1:0] grpGen,
  input  logic               carryIn,
  output logic [NUM_GRP-1:0] grpCarry   // grpCarry[k] enters group k+1
);

  // Each carry is a flat sum of products; no term waits on another carry
  always_comb begin
    logic term;
    logic chainP;
    for (int k = 0; k < NUM_GRP; k++) begin
      term   = 1'b0;
      chainP = 1'b1;
      for (int j = k; j >= 0; j--) begin
        term   = term | (grpGen[j] & chainP);
        chainP = chainP & grpProp[j];
      end
      grpCarry[k] = term | (chainP & carryIn);
    end
  end

  always_comb begin
    AST_LA_FIRST: assert (grpCarry[0] == (grpGen[0] | (grpProp[0] & carryIn)))
      else $error("first look-ahead carry wrong"); // R8
    for (int k = 1; k < NUM_GRP; k++) begin
      AST_LA_CHAIN: assert (grpCarry[k] == (grpGen[k] | (grpProp[k] & grpCarry[k-1])))
        else $error("look-ahead carry %0d inconsistent", k); // R8
    end
  end

endmodule

// File: rtl/alu16Slice.sv
module alu16Slice
  import alu16_pkg::*;
(
  input  logic [SLICE_W-1:0] sliceA,
  input  logic [SLICE_W-1:0] sliceB,
  input  logic               carryIn,
  input  aluStrobes_t        strobes,
  output logic [SLICE_W-1:0] sliceF,
  output logic               grpProp,
  output logic               grpGen
);

  logic [SLICE_W-1:0] aEff;
  logic [SLICE_W-1:0] bEff;
  sliceCore_t         core;

  assign aEff    = strobes.invA ? ~sliceA : sliceA;
  assign bEff    = strobes.invB ? ~sliceB : sliceB;
  assign core    = sliceCore(aEff, bEff, carryIn);
  assign sliceF  = sliceResult(strobes, sliceA, sliceB, core.sum);
  assign grpProp = core.grpProp;
  assign grpGen  = core.grpGen;

  always_comb begin
    if (strobes.arithEn)
      AST_SLICE_GROUP_CARRY: assert (core.carryOut == (grpGen | (grpProp & carryIn)))
        else $error("slice ripple carry disagrees with group terms"); // R8
  end

endmodule

// File: rtl/alu16Datapath.sv
module alu16Datapath
  import alu16_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] resF,
  output logic              carryOut,
  output logic              overflow
);

  localparam int LOW_SLICES = NUM_SLICES - 1;
  localparam int TOP_LSB    = LOW_SLICES * SLICE_W;
  localparam int MSB        = SLICE_W - 1;

  logic [LOW_SLICES-1:0] lowProp;
  logic [LOW_SLICES-1:0] lowGen;
  logic [LOW_SLICES-1:0] laCarry;
  logic [NUM_SLICES-1:0] sliceCin;

  assign sliceCin[0] = carryIn;

  alu16Lookahead #(
    .NUM_GRP (LOW_SLICES)
  ) u_lookahead (
    .grpProp  (lowProp),
    .grpGen   (lowGen),
    .carryIn  (carryIn),
    .grpCarry (laCarry)
  );

  for (genvar s = 0; s < LOW_SLICES; s++) begin : g_lowSlice
    assign sliceCin[s+1] = laCarry[s];
    alu16Slice u_slice (
      .sliceA  (opA[s*SLICE_W +: SLICE_W]),
      .sliceB  (opB[s*SLICE_W +: SLICE_W]),
      .carryIn (sliceCin[s]),
      .strobes (strobes),
      .sliceF  (resF[s*SLICE_W +: SLICE_W]),
      .grpProp (lowProp[s]),
      .grpGen  (lowGen[s])
    );
  end

  // Most significant slice: resolves carry-out and overflow
  logic [SLICE_W-1:0] topA;
  logic [SLICE_W-1:0] topB;
  logic [SLICE_W-1:0] topAEff;
  logic [SLICE_W-1:0] topBEff;
  sliceCore_t         topCore;

  assign topA    = opA[TOP_LSB +: SLICE_W];
  assign topB    = opB[TOP_LSB +: SLICE_W];
  assign topAEff = strobes.invA ? ~topA : topA;
  assign topBEff = strobes.invB ? ~topB : topB;
  assign topCore = sliceCore(topAEff, topBEff, sliceCin[NUM_SLICES-1]);

  assign resF[TOP_LSB +: SLICE_W] = sliceResult(strobes, topA, topB, topCore.sum);
  assign carryOut = strobes.arithEn &
                    (topCore.grpGen | (topCore.grpProp & sliceCin[NUM_SLICES-1]));
  assign overflow = strobes.arithEn & (topAEff[MSB] == topBEff[MSB]) &
                    (topCore.sum[MSB] != topAEff[MSB]);

  always_comb begin
    if (strobes.arithEn)
      AST_TOP_CARRY: assert (carryOut == topCore.carryOut)
        else $error("top slice carry-out mismatch"); // R8
    if (!strobes.arithEn)
      AST_FLAGS_QUIET: assert (!carryOut && !overflow)
        else $error("flags raised outside arithmetic"); // R6
  end

endmodule

// File: rtl/alu16Cascade.sv
module alu16Cascade
  import alu16_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SEL_W-1:0]  opSel,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resF,
  output logic              carryOut,
  output logic              overflow
);

  aluStrobes_t strobes;

  alu16Ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu16Datapath u_datapath (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .resF     (resF),
    .carryOut (carryOut),
    .overflow (overflow)
  );

  // Port-level checks against a plain wide-adder model
  logic [DATA_W:0]   fullAdd;
  logic [DATA_W:0]   fullAsubB;
  logic [DATA_W:0]   fullBsubA;
  logic [DATA_W-1:0] chkA;
  logic [DATA_W-1:0] chkB;
  logic [DATA_W-1:0] lowSum;

  always_comb begin
    fullAdd   = {1'b0, opA}  + {1'b0, opB}  + {{DATA_W{1'b0}}, carryIn};
    fullAsubB = {1'b0, opA}  + {1'b0, ~opB} + {{DATA_W{1'b0}}, carryIn};
    fullBsubA = {1'b0, ~opA} + {1'b0, opB}  + {{DATA_W{1'b0}}, carryIn};
    chkA = (opSel == OP_BSUBA) ? ~opA : opA;
    chkB = (opSel == OP_ASUBB) ? ~opB : opB;
    lowSum = {1'b0, chkA[DATA_W-2:0]} + {1'b0, chkB[DATA_W-2:0]} + {{(DATA_W-1){1'b0}}, carryIn};

    if (opSel == OP_CLEAR)
      AST_CLEAR_ZERO: assert (resF == '0 && !carryOut && !overflow)
        else $error("clear result wrong"); // R1
    if (opSel == OP_PRESET)
      AST_PRESET_ONES: assert (resF == '1 && !carryOut && !overflow)
        else $error("preset result wrong"); // R2
    if (opSel == OP_ADD)
      AST_ADD_SUM: assert ({carryOut, resF} == fullAdd)
        else $error("add result wrong"); // R3
    if (opSel == OP_ASUBB)
      AST_ASUBB_SUM: assert ({carryOut, resF} == fullAsubB)
        else $error("A minus B wrong"); // R4
    if (opSel == OP_BSUBA)
      AST_BSUBA_SUM: assert ({carryOut, resF} == fullBsubA)
        else $error("B minus A wrong"); // R5
    if (opSel == OP_ADD || opSel == OP_ASUBB || opSel == OP_BSUBA)
      AST_OVERFLOW_CARRIES: assert (overflow == (lowSum[DATA_W-1] ^ carryOut))
        else $error("overflow disagrees with msb carries"); // R7
  end

endmodule

// File: tb/alu16Cascade_tb.sv
`timescale 1ns/1ps
module alu16Cascade_tb;

  localparam int W        = 16;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   opSel = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] resF;
  logic         carryOut;
  logic         overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu16Cascade u_dut (
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .carryIn  (carryIn),
    .resF     (resF),
    .carryOut (carryOut),
    .overflow (overflow)
  );

  function automatic string reqOf(input logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R5";
      3'd2: return "R4";
      3'd3: return "R3";
      3'd7: return "R2";
      default: return "R6";
    endcase
  endfunction

  // Independent reference model
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2:0] s, input logic ci,
                       output logic [W-1:0] f, output logic co, output logic ov);
    logic [W-1:0] ae, be;
    logic [W:0]   full;
    co = 1'b0; ov = 1'b0;
    ae = (s == 3'd1) ? ~a : a;
    be = (s == 3'd2) ? ~b : b;
    full = {1'b0, ae} + {1'b0, be} + {{W{1'b0}}, ci};
    case (s)
      3'd0: f = '0;
      3'd4: f = a ^ b;
      3'd5: f = a | b;
      3'd6: f = a & b;
      3'd7: f = '1;
      default: begin
        f  = full[W-1:0];
        co = full[W];
        ov = (ae[W-1] == be[W-1]) && (full[W-1] != ae[W-1]);
      end
    endcase
  endtask

  task automatic applyCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [2:0] s, input logic ci, input string req);
    logic [W-1:0] ef;
    logic         eco, eov;
    @(posedge clk);
    #1;
    opA = a; opB = b; opSel = s; carryIn = ci;
    #3;
    model(a, b, s, ci, ef, eco, eov);
    checks++;
    if (resF !== ef || carryOut !== eco || overflow !== eov) begin
      fails++;
      $display("FAIL %s sel=%0d a=%h b=%h cin=%b: got F=%h cout=%b ovf=%b, expected F=%h cout=%b ovf=%b",
               req, s, a, b, ci, resF, carryOut, overflow, ef, eco, eov);
    end
  endtask

  task automatic tClearAndReset();
    applyCheck(16'h0000, 16'h0000, 3'd0, 1'b0, "R1");
    applyCheck(16'hFFFF, 16'hFFFF, 3'd0, 1'b1, "R1");
    applyCheck(16'h8000, 16'h7FFF, 3'd0, 1'b1, "R9");
  endtask

  task automatic tPreset();
    applyCheck(16'h0000, 16'h0000, 3'd7, 1'b0, "R2");
    applyCheck(16'hFFFF, 16'h0001, 3'd7, 1'b1, "R2");
  endtask

  task automatic tAdd();
    applyCheck(16'h1234, 16'h4321, 3'd3, 1'b0, "R3");
    applyCheck(16'hFFFF, 16'hFFFF, 3'd3, 1'b1, "R3");
    applyCheck(16'h7FFF, 16'h0001, 3'd3, 1'b0, "R7");
    applyCheck(16'h8000, 16'h8000, 3'd3, 1'b0, "R7");
    applyCheck(16'h7FFF, 16'h0000, 3'd3, 1'b1, "R7");
  endtask

  task automatic tSubAB();
    applyCheck(16'h0005, 16'h0003, 3'd2, 1'b1, "R4");
    applyCheck(16'h0003, 16'h0005, 3'd2, 1'b1, "R4");
    applyCheck(16'h0000, 16'h0000, 3'd2, 1'b1, "R4");
    applyCheck(16'h8000, 16'h0001, 3'd2, 1'b1, "R7");
    applyCheck(16'h1000, 16'h0001, 3'd2, 1'b0, "R4");
  endtask

  task automatic tSubBA();
    applyCheck(16'h0003, 16'h0005, 3'd1, 1'b1, "R5");
    applyCheck(16'h0005, 16'h0003, 3'd1, 1'b1, "R5");
    applyCheck(16'h0001, 16'h8000, 3'd1, 1'b1, "R7");
    applyCheck(16'hFFFF, 16'h7FFF, 3'd1, 1'b1, "R7");
  endtask

  task automatic tLogic();
    for (int s = 4; s <= 6; s++) begin
      applyCheck(16'hF0F0, 16'hFF00, 3'(s), 1'b0, "R6");
      applyCheck(16'hF0F0, 16'hFF00, 3'(s), 1'b1, "R9");
      applyCheck(16'hFFFF, 16'h0001, 3'(s), 1'b1, "R9");
    end
  endtask

  task automatic tCarryChain();
    applyCheck(16'h0FFF, 16'h0001, 3'd3, 1'b0, "R8");
    applyCheck(16'h00FF, 16'h0F00, 3'd3, 1'b1, "R8");
    applyCheck(16'hFFFF, 16'h0000, 3'd3, 1'b1, "R8");
    applyCheck(16'h000F, 16'h0001, 3'd3, 1'b0, "R8");
    applyCheck(16'h1000, 16'h0001, 3'd2, 1'b1, "R8");
    applyCheck(16'h0000, 16'h0001, 3'd2, 1'b1, "R8");
  endtask

  task automatic tCornersAndRandom();
    logic [W-1:0] corner [4];
    corner[0] = 16'h0000; corner[1] = 16'hFFFF;
    corner[2] = 16'h7FFF; corner[3] = 16'h8000;
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          applyCheck(corner[i], corner[j], 3'(s), 1'(j[0]), reqOf(3'(s)));
      for (int n = 0; n < 40; n++)
        applyCheck(16'($urandom), 16'($urandom), 3'(s), 1'($urandom), reqOf(3'(s)));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    tClearAndReset();
    tPreset();
    tAdd();
    tSubAB();
    tSubBA();
    tLogic();
    tCarryChain();
    tCornersAndRandom();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule